// File: doc/BRIEF.md
# Link-Side Interface Reset Sequencer

This block lives on the link side of a serial-bus PHY-to-link connection and owns the link power status line (`lps`). In normal service it holds `lps` high. It also forwards link traffic (request, control and data beats) to the PHY-facing pins. Each of those pins is modelled as a value plus an output enable.

The reset command is honoured only in differentiated mode, which means `iso_mode` is low. On that command the block does three things in order:
- It drops `lps`.
- It drives every link output to logic 0 for a fixed number of cycles.
- It releases all the outputs by lowering their enables, well inside a hard release deadline.

After the release, `lps` stays low for the PHY's detect window and then for a restore window. Only after both windows does the block report that the restore interval is complete. A re-enable request raises `lps` again and emits a one-cycle pulse that starts the initialization logic. A re-enable request that arrives early is remembered until the restore interval has ended.

Link traffic enters on a valid/ready stream. The block raises `tx_ready` only while it is in normal service and no reset command is being accepted in the same cycle. A beat is taken only when `tx_valid` and `tx_ready` are both high; otherwise the source must hold the beat. `tx_ready` does not depend on `tx_valid`. All timer lengths are parameters counted in system clock cycles.

Top module: `link_lps_reset`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it falls, the block shows: `lps`=1; `lreq_oe`, `ctl_oe` and `d_oe` all 1; `lreq_o`, `ctl_o` and `d_o` all 0; `tx_ready`=1; `restore_done`=0; `init_start`=0.
- R2: In normal service, a beat accepted at a clock edge appears on `lreq_o`, `ctl_o` and `d_o` in the cycle after that edge. When no beat is accepted, those outputs show 0 in the next cycle.
- R3: When `reset_req` is high with `iso_mode` low in normal service, `tx_ready` is low in that same cycle. In the next cycle `lps`=0, all enables stay 1 and all outputs are 0.
- R4: In normal service, `reset_req` has no effect while `iso_mode` is high, and `reenable_req` has no effect at all: `lps` stays 1 and traffic keeps flowing.
- R5: After `lps` falls, the enables stay high with outputs at 0 for exactly ZERO_CYC cycles and then all go low together. ZERO_CYC may not exceed RELEASE_MAX_CYC.
- R6: Whenever an output enable is low, the matching output value is 0, and the last value driven before the enable falls is 0.
- R7: `lps` stays low for exactly ZERO_CYC+DETECT_CYC+RESTORE_CYC cycles before `restore_done` rises. It stays low for at least DETECT_CYC+RESTORE_CYC cycles in every case.
- R8: `restore_done` is high only while the block is waiting for re-enable, and stays high until the re-enable is acted on. A re-enable in that state sets `lps`=1 and `init_start`=1 in the next cycle, with all enables high. `init_start` is 0 in the cycle after that.
- R9: A `reenable_req` pulse seen at any point after the reset command and before the waiting state is held. `restore_done` is then high for exactly one cycle, followed by `lps`=1 with `init_start`=1.
- R10: A `reset_req` that arrives during an ongoing sequence is ignored; the sequence timing stays as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_mode | input | 1 | High = isolated mode; the reset command is honoured only when this is low |
| reset_req | input | 1 | Command to start the interface reset sequence |
| reenable_req | input | 1 | Request to raise `lps` again |
| tx_valid | input | 1 | A link beat is offered |
| tx_ready | output | 1 | The block accepts the offered beat this cycle |
| tx_lreq | input | 1 | Request bit of the beat |
| tx_ctl | input | CTL_W | Control bits of the beat |
| tx_d | input | D_W | Data bits of the beat |
| lps | output | 1 | Link power status toward the PHY |
| lreq_o | output | 1 | Request pin value |
| lreq_oe | output | 1 | Request pin output enable |
| ctl_o | output | CTL_W | Control pin values |
| ctl_oe | output | 1 | Control pin output enable |
| d_o | output | D_W | Data pin values |
| d_oe | output | 1 | Data pin output enable |
| restore_done | output | 1 | The minimum restore interval has completed |
| init_start | output | 1 | One-cycle pulse when `lps` is raised again |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a reset command and a traffic beat. The bench offers a valid beat in the very cycle it raises `reset_req`. It then checks two things: `tx_ready` is already low in that cycle, and the beat never reaches the pins, which go straight to driven zeros.

The second pair is a re-enable request and the sequence reaching its waiting state. The bench pulses `reenable_req` well before that point. It then checks that `restore_done` lasts exactly one cycle and is followed at once by `lps` high and the `init_start` pulse.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_DROP    = 3'd1,
    ST_RELEASE = 3'd2,
    ST_RWAIT   = 3'd3,
    ST_READY   = 3'd4
  } lrs_state_e;

  function automatic int unsigned lrs_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lrs_timer.sv
module lrs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != {CW{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/lrs_drv.sv
module lrs_drv #(
  parameter int W = 1
) (
  input  logic         drive_en,
  input  logic         zero_force,
  input  logic [W-1:0] val,
  output logic [W-1:0] o,
  output logic         oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign o[i] = drive_en & ~zero_force & val[i];
  end
  assign oe = drive_en;
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
  import lrs_pkg::*;
#(
  parameter int ZERO_CYC        = 4,
  parameter int DETECT_CYC      = 128,
  parameter int RESTORE_CYC     = 1024,
  parameter int RELEASE_MAX_CYC = 49152
) (
  input  logic clk,
  input  logic rst,
  input  logic iso_mode,
  input  logic reset_req,
  input  logic reenable_req,
  output logic lps,
  output logic drive_en,
  output logic zero_force,
  output logic accept_ok,
  output logic restore_done,
  output logic init_start
);
  localparam int unsigned MAXL = lrs_max3(ZERO_CYC, DETECT_CYC, RESTORE_CYC);
  localparam int CW = $clog2(MAXL + 1) + 1;
  localparam int LOW_MIN = DETECT_CYC + RESTORE_CYC;
  localparam int AW = $clog2(LOW_MIN + RELEASE_MAX_CYC + 2) + 1;

  lrs_state_e    state, state_n;
  logic          pend;
  logic          go;
  logic          last;
  logic          tmr_clr;
  logic [CW-1:0] limit;
  logic          start;

  assign start = (state == ST_NORMAL) && reset_req && !iso_mode;
  assign go    = (state == ST_READY) && (reenable_req || pend);

  always_comb begin
    unique case (state)
      ST_DROP:    limit = CW'(ZERO_CYC);
      ST_RELEASE: limit = CW'(DETECT_CYC);
      ST_RWAIT:   limit = CW'(RESTORE_CYC);
      default:    limit = CW'(1);
    endcase
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_NORMAL:  if (start) state_n = ST_DROP;
      ST_DROP:    if (last)  state_n = ST_RELEASE;
      ST_RELEASE: if (last)  state_n = ST_RWAIT;
      ST_RWAIT:   if (last)  state_n = ST_READY;
      ST_READY:   if (go)    state_n = ST_NORMAL;
      default:               state_n = ST_NORMAL;
    endcase
  end

  assign tmr_clr = (state_n != state) || (state == ST_NORMAL) || (state == ST_READY);

  lrs_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (limit),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_NORMAL;
      pend       <= 1'b0;
      init_start <= 1'b0;
    end else begin
      state      <= state_n;
      init_start <= go;
      if (state == ST_NORMAL || go) pend <= 1'b0;
      else if (reenable_req)        pend <= 1'b1;
    end
  end

  assign lps          = (state == ST_NORMAL);
  assign drive_en     = (state == ST_NORMAL) || (state == ST_DROP);
  assign zero_force   = (state != ST_NORMAL);
  assign accept_ok    = (state == ST_NORMAL) && !start;
  assign restore_done = (state == ST_READY);

  // Checker counters, used only by the properties below.
  logic [AW-1:0] low_cnt;
  logic [AW-1:0] drv_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || lps) begin
      low_cnt     <= '0;
      drv_low_cnt <= '0;
    end else begin
      if (low_cnt != {AW{1'b1}}) low_cnt <= low_cnt + 1'b1;
      if (drive_en && drv_low_cnt != {AW{1'b1}}) drv_low_cnt <= drv_low_cnt + 1'b1;
    end
  end

  initial begin
    // R5
    release_fits_chk: assert (ZERO_CYC >= 1 && ZERO_CYC <= RELEASE_MAX_CYC
                              && DETECT_CYC >= 1 && RESTORE_CYC >= 1);
  end

  // R5
  release_deadline_chk: assert property (@(posedge clk) disable iff (rst)
    drv_low_cnt <= AW'(RELEASE_MAX_CYC));

  // R7
  lps_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lps) |-> ($past(low_cnt) >= AW'(LOW_MIN)));

  // R9
  pend_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READY && pend) |=> (state == ST_NORMAL));

  // R8
  init_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    init_start |-> (lps && $past(restore_done)));
endmodule

// File: rtl/link_lps_reset.sv
module link_lps_reset #(
  parameter int CTL_W           = 2,
  parameter int D_W             = 8,
  parameter int ZERO_CYC        = 4,
  parameter int DETECT_CYC      = 128,
  parameter int RESTORE_CYC     = 1024,
  parameter int RELEASE_MAX_CYC = 49152
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iso_mode,
  input  logic             reset_req,
  input  logic             reenable_req,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             tx_lreq,
  input  logic [CTL_W-1:0] tx_ctl,
  input  logic [D_W-1:0]   tx_d,
  output logic             lps,
  output logic             lreq_o,
  output logic             lreq_oe,
  output logic [CTL_W-1:0] ctl_o,
  output logic             ctl_oe,
  output logic [D_W-1:0]   d_o,
  output logic             d_oe,
  output logic             restore_done,
  output logic             init_start
);
  localparam int PW = 1 + CTL_W + D_W;

  logic          drive_en, zero_force, accept_ok;
  logic [PW-1:0] pay_q;

  lrs_fsm #(
    .ZERO_CYC        (ZERO_CYC),
    .DETECT_CYC      (DETECT_CYC),
    .RESTORE_CYC     (RESTORE_CYC),
    .RELEASE_MAX_CYC (RELEASE_MAX_CYC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .iso_mode     (iso_mode),
    .reset_req    (reset_req),
    .reenable_req (reenable_req),
    .lps          (lps),
    .drive_en     (drive_en),
    .zero_force   (zero_force),
    .accept_ok    (accept_ok),
    .restore_done (restore_done),
    .init_start   (init_start)
  );

  assign tx_ready = accept_ok;

  always_ff @(posedge clk) begin
    if (rst)                       pay_q <= '0;
    else if (tx_valid && tx_ready) pay_q <= {tx_lreq, tx_ctl, tx_d};
    else                           pay_q <= '0;
  end

  lrs_drv #(.W(1)) u_lreq (
    .drive_en (drive_en), .zero_force (zero_force),
    .val (pay_q[PW-1]), .o (lreq_o), .oe (lreq_oe));

  lrs_drv #(.W(CTL_W)) u_ctl (
    .drive_en (drive_en), .zero_force (zero_force),
    .val (pay_q[D_W +: CTL_W]), .o (ctl_o), .oe (ctl_oe));

  lrs_drv #(.W(D_W)) u_d (
    .drive_en (drive_en), .zero_force (zero_force),
    .val (pay_q[D_W-1:0]), .o (d_o), .oe (d_oe));

  // R6
  last_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(d_oe) |-> ($past(d_o) == '0 && $past(ctl_o) == '0 && $past(lreq_o) == 1'b0));

  // R3
  lps_drop_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lps) |-> (d_oe && ctl_oe && lreq_oe && d_o == '0 && ctl_o == '0 && !lreq_o));

  // R5
  enables_together_chk: assert property (@(posedge clk) disable iff (rst)
    (d_oe == ctl_oe) && (ctl_oe == lreq_oe));

  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    restore_done |-> (!lps && !d_oe));

  // R4
  iso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lps && iso_mode) |=> lps);
endmodule

// File: tb/link_lps_reset_bench.sv
module link_lps_reset_bench;
  localparam int ZC = 3, DC = 5, RC = 7, RMAX = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iso_mode = 1'b0, reset_req = 1'b0, reenable_req = 1'b0;
  logic tx_valid = 1'b0, tx_lreq = 1'b0;
  logic [1:0] tx_ctl = '0;
  logic [7:0] tx_d = '0;
  logic tx_ready, lps, lreq_o, lreq_oe, ctl_oe, d_oe, restore_done, init_start;
  logic [1:0] ctl_o;
  logic [7:0] d_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  link_lps_reset #(.CTL_W(2), .D_W(8), .ZERO_CYC(ZC), .DETECT_CYC(DC),
                   .RESTORE_CYC(RC), .RELEASE_MAX_CYC(RMAX)) u_link_lps_reset (
    .clk(clk), .rst(rst), .iso_mode(iso_mode), .reset_req(reset_req),
    .reenable_req(reenable_req), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_lreq(tx_lreq), .tx_ctl(tx_ctl), .tx_d(tx_d), .lps(lps),
    .lreq_o(lreq_o), .lreq_oe(lreq_oe), .ctl_o(ctl_o), .ctl_oe(ctl_oe),
    .d_o(d_o), .d_oe(d_oe), .restore_done(restore_done), .init_start(init_start));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // Samples from one cycle after the reset command until restore_done rises.
  task automatic run_to_ready(output int n_low, output int n_oe, output int n_bad0,
                              input int mid_req_at, input int reen_at);
    n_low = 0; n_oe = 0; n_bad0 = 0;
    for (int i = 0; i < 100; i++) begin
      if (restore_done) break;
      if (lps) n_bad0++;
      if (d_oe) n_oe++;
      if (!d_oe && (d_o != 0 || ctl_o != 0 || lreq_o)) n_bad0++;
      n_low++;
      reset_req    = (i == mid_req_at);
      reenable_req = (i == reen_at);
      step();
    end
    reset_req = 1'b0; reenable_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    chk(lps && lreq_oe && ctl_oe && d_oe, "R1 lps/enables in reset", {lps, d_oe}, 3);
    chk(d_o == 0 && ctl_o == 0 && !lreq_o, "R1 outputs zero in reset", d_o, 0);
    rst = 1'b0; step();
    chk(tx_ready && !restore_done && !init_start && lps, "R1 after reset",
        {tx_ready, restore_done, init_start}, 4);
  endtask

  task automatic t_pass();
    tx_valid = 1'b1; tx_lreq = 1'b1; tx_ctl = 2'b10; tx_d = 8'hA5; step();
    chk(d_o == 8'hA5 && ctl_o == 2'b10 && lreq_o, "R2 beat A5", d_o, 8'hA5);
    tx_lreq = 1'b0; tx_ctl = 2'b01; tx_d = 8'h3C; step();
    chk(d_o == 8'h3C && ctl_o == 2'b01 && !lreq_o, "R2 beat 3C", d_o, 8'h3C);
    tx_valid = 1'b0; step();
    chk(d_o == 0 && ctl_o == 0 && d_oe, "R2 idle zero", d_o, 0);
  endtask

  task automatic t_ignored();
    iso_mode = 1'b1; reset_req = 1'b1; reenable_req = 1'b1;
    tx_valid = 1'b1; tx_d = 8'h5A; step();
    iso_mode = 1'b0; reset_req = 1'b0; reenable_req = 1'b0; tx_valid = 1'b0;
    chk(lps && d_oe && d_o == 8'h5A, "R4 iso high / reenable ignored", d_o, 8'h5A);
    step();
    chk(lps && tx_ready && !init_start, "R4 still normal", lps, 1);
  endtask

  task automatic finish_reenable(input string tag);
    reenable_req = 1'b1; step(); reenable_req = 1'b0;
    chk(lps && init_start && d_oe && ctl_oe && lreq_oe, {tag, " relaunch"},
        {lps, init_start, d_oe}, 7);
    step();
    chk(!init_start && lps, {tag, " pulse one cycle"}, init_start, 0);
  endtask

  task automatic t_sequence();
    int nl, no, nb;
    reset_req = 1'b1;
    #1 chk(!tx_ready, "R3 ready low with command", tx_ready, 0);
    step(); reset_req = 1'b0;
    chk(!lps && d_oe && d_o == 0 && ctl_o == 0, "R3 lps low, zeros driven", lps, 0);
    run_to_ready(nl, no, nb, -1, -1);
    chk(no == ZC, "R5 zero-drive cycles", no, ZC);
    chk(nb == 0, "R6 released outputs zero", nb, 0);
    chk(nl == ZC + DC + RC, "R7 lps low length", nl, ZC + DC + RC);
    step(); step();
    chk(restore_done && !lps && !d_oe, "R8 done holds", restore_done, 1);
    finish_reenable("R8");
  endtask

  task automatic t_pending();
    int nl, no, nb;
    reset_req = 1'b1; step(); reset_req = 1'b0;
    run_to_ready(nl, no, nb, -1, ZC + 1);
    chk(restore_done && nl == ZC + DC + RC, "R9 reached ready", nl, ZC + DC + RC);
    step();
    chk(lps && init_start && !restore_done, "R9 held reenable applied",
        {lps, init_start}, 3);
    step();
  endtask

  task automatic t_collision();
    int nl, no, nb;
    tx_valid = 1'b1; tx_lreq = 1'b1; tx_ctl = 2'b11; tx_d = 8'hFF; reset_req = 1'b1;
    #1 chk(!tx_ready, "R3 beat refused on command", tx_ready, 0);
    step(); reset_req = 1'b0;
    chk(d_o == 0 && ctl_o == 0 && !lreq_o && !lps, "R3 beat not driven", d_o, 0);
    run_to_ready(nl, no, nb, ZC + 2, -1);
    tx_valid = 1'b0;
    chk(nl == ZC + DC + RC, "R10 mid-sequence command ignored", nl, ZC + DC + RC);
    finish_reenable("R10");
  endtask

  initial begin
    step();
    t_reset();
    t_pass();
    t_ignored();
    t_sequence();
    t_pending();
    t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule